// File: doc/BRIEF.md
# AC-Link Capture Slot Mapper

This block takes one left and one right 16-bit audio capture sample per frame and places them on the serial input line of an AC-Link style frame. The frame is 256 bit clocks long: a 16-bit tag slot, then twelve 20-bit data slots. A 2-bit code picks which pair of data slots carries the audio. Each tag bit that marks a slot valid is raised only for the two audio slots in use. All other slots are driven as zeros.

Each capture path has its own power-down input, and a global power-down stops both. When only one path is running, its sample fills both selected slots. Each path has a first-order DC-blocking high-pass filter. A bypass input turns the filter off and sends the raw sample to the frame. A frame starts on the first bit clock on which the sync input is seen high. All inputs are captured on that clock and held for the whole frame.

Top module: `aclink_slot_mapper`

## Requirements
- R1: On the clock edge where `sync_in` is first sampled high (it was low on the edge before), a frame starts. Frame bit 0 appears on `sdata_out` after the next edge, and frame bit k after edge start+1+k, for k = 0..255. Bits 0..15 are the tag slot, MSB first. Data slot s (1..12) covers frame bits 16+20(s-1) to 35+20(s-1).
- R2: In the tag slot, frame bit 0 equals `codec_ready`. Frame bit s (s = 1..12) is the valid tag for data slot s. Frame bits 13..15 are zero.
- R3: `slot_sel` maps the left and right samples to data slots as follows: 00 → slots 3 and 4, 01 → slots 7 and 8, 10 → slots 6 and 9, 11 → slots 10 and 11. The tags of exactly these two slots are set when at least one path is enabled.
- R4: A sample goes out MSB first in the first 16 bits of its 20-bit slot, followed by 4 zero bits. Every unselected data slot is all zeros.
- R5: The left path is enabled when both `pd_left` and `pd_all` are low. The right path is enabled when both `pd_right` and `pd_all` are low.
- R6: When exactly one path is enabled, that path's sample is sent in both selected slots.
- R7: When neither path is enabled, both selected slots are zero and all twelve valid tags are clear.
- R8: With the filter active (`hpf_bypass` = 0), each enabled path computes y = (x − x_prev) + y_prev − (y_prev >>> 10) once per frame. The arithmetic is two's complement and the state starts at zero. The value sent is y saturated to the range −32768..32767.
- R9: With `hpf_bypass` = 1, the raw sample is sent. The filter state of an enabled path still updates on that frame.
- R10: A path that is disabled at a frame start has its filter state cleared. Its next enabled frame therefore sends y = x.
- R11: After reset, and from the edge after the last bit of a frame until the next frame start, `sdata_out` is 0.
- R12: Changes to the samples, `slot_sel`, `hpf_bypass`, `codec_ready` and the power-down inputs after a frame start have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Frame sync; a rising level marks the frame start |
| codec_ready | input | 1 | Value sent in the first tag bit |
| slot_sel | input | 2 | Slot-pair selection code |
| pd_left | input | 1 | Left path power-down |
| pd_right | input | 1 | Right path power-down |
| pd_all | input | 1 | Power-down of both paths |
| hpf_bypass | input | 1 | 1 sends raw samples, 0 sends filtered samples |
| left_sample | input | 16 | Left capture sample, two's complement |
| right_sample | input | 16 | Right capture sample, two's complement |
| sdata_out | output | 1 | Serial frame output |

## Verification
Some properties are checked on every cycle:
- a frame start resets the bit position;
- the three spare tag bits and the four pad bits of every data slot stay low on the line;
- the captured tag word always holds either zero or exactly two valid tags;
- a fully powered-down capture clears all tags;
- a lone enabled path feeds identical data to both slots;
- a disabled path's filter state is cleared.

Other behaviour shows only in the bench's frames, which are compared bit for bit against a model:
- the exact slot positions for each select code;
- the filter's arithmetic and saturation;
- the state carried through a bypassed frame;
- immunity to input changes in the middle of a frame.

// File: rtl/acm_pkg.sv
// Shared frame geometry and slot-pair mapping for the capture slot mapper.
// Assumes a 16-bit tag slot followed by twelve 20-bit data slots.
package acm_pkg;
    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_W);

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    typedef struct packed {
        slot_idx_t left_slot;
        slot_idx_t right_slot;
    } slot_pair_t;

    // Translate the 2-bit select code into the left/right data slot numbers.
    function automatic slot_pair_t map_slots(input logic [1:0] code);
        slot_pair_t p;
        case (code)
            2'b01:   begin p.left_slot = SLOT_IDX_W'(7);  p.right_slot = SLOT_IDX_W'(8);  end
            2'b10:   begin p.left_slot = SLOT_IDX_W'(6);  p.right_slot = SLOT_IDX_W'(9);  end
            2'b11:   begin p.left_slot = SLOT_IDX_W'(10); p.right_slot = SLOT_IDX_W'(11); end
            default: begin p.left_slot = SLOT_IDX_W'(3);  p.right_slot = SLOT_IDX_W'(4);  end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/acm_dc_blocker.sv
// First-order DC-blocking filter, updated once per frame on `update`.
// filt_out is the saturated value the filter produces on this update.
// The state clears when `update` arrives while the path is disabled.
// Assumes ACC_W is wide enough to hold about 2^POLE_SHIFT full-scale steps.
module acm_dc_blocker #(
    parameter int SAMPLE_W   = 16,
    parameter int POLE_SHIFT = 10,
    parameter int ACC_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                update,
    input  logic                enable,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] filt_out
);
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -MAX_V - 1;

    logic signed [ACC_W-1:0] x_ext, xp_q, y_q, acc;

    // Sign-extend the input and form the next filter state.
    always_comb begin
        x_ext = {{(ACC_W-SAMPLE_W){sample_in[SAMPLE_W-1]}}, sample_in};
        acc   = x_ext - xp_q + y_q - (y_q >>> POLE_SHIFT);
    end

    // Clamp the new state into the output sample range.
    always_comb begin
        if (acc > MAX_V)      filt_out = MAX_V[SAMPLE_W-1:0];
        else if (acc < MIN_V) filt_out = MIN_V[SAMPLE_W-1:0];
        else                  filt_out = acc[SAMPLE_W-1:0];
    end

    // Advance or clear the state once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp_q <= '0;
            y_q  <= '0;
        end else if (update) begin
            if (enable) begin
                xp_q <= x_ext;
                y_q  <= acc;
            end else begin
                xp_q <= '0;
                y_q  <= '0;
            end
        end
    end

    a_r10_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !enable) |=> (y_q == '0 && xp_q == '0));
endmodule

// File: rtl/acm_frame_bit.sv
// Selects the frame bit for the current slot and bit position.
// Purely combinational. Assumes SAMPLE_W <= SLOT_W and distinct slot_a/slot_b.
module acm_frame_bit
    import acm_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  slot_idx_t             slot_idx,
    input  logic [BIT_IDX_W-1:0]  bit_idx,
    input  logic [TAG_W-1:0]      tag_word,
    input  slot_idx_t             slot_a,
    input  slot_idx_t             slot_b,
    input  logic [SAMPLE_W-1:0]   data_a,
    input  logic [SAMPLE_W-1:0]   data_b,
    output logic                  frame_bit
);
    logic [TAG_W-1:0]  tag_sh;
    logic [SLOT_W-1:0] pad_a, pad_b, sh_a, sh_b;

    // Left-justify samples in their slot and shift the wanted bit to the MSB.
    always_comb begin
        tag_sh = tag_word << bit_idx;
        pad_a  = SLOT_W'(data_a) << (SLOT_W - SAMPLE_W);
        pad_b  = SLOT_W'(data_b) << (SLOT_W - SAMPLE_W);
        sh_a   = pad_a << bit_idx;
        sh_b   = pad_b << bit_idx;
    end

    // Pick the source by slot number; unused slots give zero.
    always_comb begin
        if (slot_idx == '0)          frame_bit = tag_sh[TAG_W-1];
        else if (slot_idx == slot_a) frame_bit = sh_a[SLOT_W-1];
        else if (slot_idx == slot_b) frame_bit = sh_b[SLOT_W-1];
        else                         frame_bit = 1'b0;
    end
endmodule

// File: rtl/acm_serializer.sv
// Finds the frame start from the sync level and walks slot/bit counters
// through one 256-bit frame. It registers the selected bit onto the line.
// Assumes sync is low on at least one clock between frame starts.
module acm_serializer
    import acm_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_in,
    input  logic                 frame_bit,
    output logic                 start,
    output slot_idx_t            slot_idx,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 sdata_out
);
    logic      sync_d, active_q, last_bit;
    slot_idx_t slot_q;
    logic [BIT_IDX_W-1:0] bit_q;

    // Frame start and end-of-slot decode.
    always_comb begin
        start    = sync_in & ~sync_d;
        last_bit = (slot_q == '0) ? (bit_q == BIT_IDX_W'(TAG_W - 1))
                                  : (bit_q == BIT_IDX_W'(SLOT_W - 1));
    end

    assign slot_idx = slot_q;
    assign bit_idx  = bit_q;

    // Position counters and the registered serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d    <= 1'b0;
            active_q  <= 1'b0;
            slot_q    <= '0;
            bit_q     <= '0;
            sdata_out <= 1'b0;
        end else begin
            sync_d    <= sync_in;
            sdata_out <= active_q & frame_bit;
            if (start) begin
                active_q <= 1'b1;
                slot_q   <= '0;
                bit_q    <= '0;
            end else if (active_q) begin
                if (last_bit) begin
                    bit_q <= '0;
                    if (slot_q == SLOT_IDX_W'(NUM_SLOTS)) active_q <= 1'b0;
                    else                                 slot_q   <= slot_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    a_r1_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active_q && slot_q == '0 && bit_q == '0));
    a_r2_spare_tags_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && slot_q == '0 && bit_q >= BIT_IDX_W'(TAG_W - 3)) |=> !sdata_out);
    a_r4_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && slot_q != '0 && bit_q >= BIT_IDX_W'(SAMPLE_W)) |=> !sdata_out);
endmodule

// File: rtl/aclink_slot_mapper.sv
// Places left/right capture samples into a selectable slot pair of an
// AC-Link style input frame. It handles per-path power-down, copies a lone
// live channel into both slots, and can bypass the DC filter. All controls
// and samples are captured at the frame start.
module aclink_slot_mapper
    import acm_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int POLE_SHIFT = 10,
    parameter int ACC_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic                codec_ready,
    input  logic [1:0]          slot_sel,
    input  logic                pd_left,
    input  logic                pd_right,
    input  logic                pd_all,
    input  logic                hpf_bypass,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                sdata_out
);
    localparam int NCH = 2;

    logic                 start, frame_bit, any_en;
    slot_idx_t            slot_idx;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [SAMPLE_W-1:0]  raw_s [NCH];
    logic [SAMPLE_W-1:0]  filt_s[NCH];
    logic [SAMPLE_W-1:0]  out_s [NCH];
    logic                 en_s  [NCH];
    slot_pair_t           pair;
    logic [TAG_W-1:0]     tag_next, snap_tag_q;
    logic [SAMPLE_W-1:0]  data_a, data_b, snap_a_q, snap_b_q;
    slot_idx_t            snap_slot_a_q, snap_slot_b_q;

    // Per-path enables and raw inputs (index 0 = left, 1 = right).
    always_comb begin
        raw_s[0] = left_sample;
        raw_s[1] = right_sample;
        en_s[0]  = ~(pd_left  | pd_all);
        en_s[1]  = ~(pd_right | pd_all);
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_path
        acm_dc_blocker #(
            .SAMPLE_W(SAMPLE_W), .POLE_SHIFT(POLE_SHIFT), .ACC_W(ACC_W)
        ) u_hpf (
            .clk(clk), .rst_n(rst_n), .update(start), .enable(en_s[ch]),
            .sample_in(raw_s[ch]), .filt_out(filt_s[ch])
        );
        // Choose filtered or raw data for this path.
        assign out_s[ch] = hpf_bypass ? raw_s[ch] : filt_s[ch];
    end

    // Slot routing, single-channel copy and valid tags for the next frame.
    always_comb begin
        pair   = map_slots(slot_sel);
        any_en = en_s[0] | en_s[1];
        data_a = en_s[0] ? out_s[0] : (en_s[1] ? out_s[1] : '0);
        data_b = en_s[1] ? out_s[1] : (en_s[0] ? out_s[0] : '0);
        tag_next = '0;
        tag_next[TAG_W-1] = codec_ready;
        for (int s = 1; s <= NUM_SLOTS; s++) begin
            if (any_en && (pair.left_slot == SLOT_IDX_W'(s) || pair.right_slot == SLOT_IDX_W'(s)))
                tag_next[TAG_W-1-s] = 1'b1;
        end
    end

    // Hold the frame contents steady from one frame start to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_tag_q    <= '0;
            snap_a_q      <= '0;
            snap_b_q      <= '0;
            snap_slot_a_q <= SLOT_IDX_W'(3);
            snap_slot_b_q <= SLOT_IDX_W'(4);
        end else if (start) begin
            snap_tag_q    <= tag_next;
            snap_a_q      <= data_a;
            snap_b_q      <= data_b;
            snap_slot_a_q <= pair.left_slot;
            snap_slot_b_q <= pair.right_slot;
        end
    end

    acm_frame_bit #(.SAMPLE_W(SAMPLE_W)) u_bit (
        .slot_idx(slot_idx), .bit_idx(bit_idx), .tag_word(snap_tag_q),
        .slot_a(snap_slot_a_q), .slot_b(snap_slot_b_q),
        .data_a(snap_a_q), .data_b(snap_b_q), .frame_bit(frame_bit)
    );

    acm_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .frame_bit(frame_bit),
        .start(start), .slot_idx(slot_idx), .bit_idx(bit_idx), .sdata_out(sdata_out)
    );

    a_r3_two_tags: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(snap_tag_q[TAG_W-2:TAG_W-1-NUM_SLOTS]) == 0 ||
         $countones(snap_tag_q[TAG_W-2:TAG_W-1-NUM_SLOTS]) == 2));
    a_r7_off_no_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (pd_all || (pd_left && pd_right))) |=> (snap_tag_q[TAG_W-2:0] == '0));
    a_r6_copy_left: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pd_all && !pd_left && pd_right) |=> (snap_a_q == snap_b_q));
    a_r6_copy_right: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pd_all && pd_left && !pd_right) |=> (snap_a_q == snap_b_q));
endmodule

// File: tb/aclink_slot_mapper_bench.sv
`timescale 1ns/100ps
module aclink_slot_mapper_bench;
    logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, codec_ready = 1'b0;
    logic [1:0] slot_sel = 2'b00;
    logic pd_left = 1'b0, pd_right = 1'b0, pd_all = 1'b0, hpf_bypass = 1'b0;
    logic [15:0] left_sample = '0, right_sample = '0;
    logic sdata_out;

    int tests = 0, fails = 0;
    longint xpl = 0, yl = 0, xpr = 0, yr = 0;

    typedef struct { logic [255:0] bits; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    aclink_slot_mapper u_aclink_slot_mapper (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .codec_ready(codec_ready),
        .slot_sel(slot_sel), .pd_left(pd_left), .pd_right(pd_right), .pd_all(pd_all),
        .hpf_bypass(hpf_bypass), .left_sample(left_sample), .right_sample(right_sample),
        .sdata_out(sdata_out)
    );

    function automatic logic [15:0] sat16(input longint v);
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    // Model of R8/R10: one filter step per frame, or a clear when disabled.
    task automatic model_hpf(input bit en, input logic [15:0] x, inout longint xp,
                             inout longint y, output logic [15:0] f);
        longint xs, acc;
        xs = longint'($signed(x));
        if (en) begin
            acc = xs - xp + y - (y >>> 10);
            xp = xs; y = acc; f = sat16(acc);
        end else begin
            xp = 0; y = 0; f = '0;
        end
    endtask

    // Expected frame; index k is the k-th bit on the line (R1..R7).
    function automatic logic [255:0] build(input logic rdy, input logic [1:0] sel,
            input bit enl, input bit enr, input logic [15:0] dl, input logic [15:0] dr);
        logic [255:0] f = '0;
        int sa, sb;
        logic [15:0] va, vb;
        case (sel)
            2'b00: begin sa = 3;  sb = 4;  end
            2'b01: begin sa = 7;  sb = 8;  end
            2'b10: begin sa = 6;  sb = 9;  end
            default: begin sa = 10; sb = 11; end
        endcase
        va = enl ? dl : (enr ? dr : 16'h0);
        vb = enr ? dr : (enl ? dl : 16'h0);
        f[0] = rdy;
        if (enl || enr) begin f[sa] = 1'b1; f[sb] = 1'b1; end
        for (int i = 0; i < 16; i++) begin
            f[16 + 20*(sa-1) + i] = va[15-i];
            f[16 + 20*(sb-1) + i] = vb[15-i];
        end
        return f;
    endfunction

    task automatic set_in(input logic rdy, input logic [1:0] sel, input logic pdl,
            input logic pdr, input logic pda, input logic byp,
            input logic [15:0] l, input logic [15:0] r);
        codec_ready = rdy; slot_sel = sel; pd_left = pdl; pd_right = pdr;
        pd_all = pda; hpf_bypass = byp; left_sample = l; right_sample = r;
    endtask

    // Driver: push the expected frame, then play one sync pulse and a gap.
    task automatic run_frame(input string req, input bit mid_change);
        exp_t e;
        bit enl, enr;
        logic [15:0] fl, fr;
        enl = !(pd_left || pd_all);
        enr = !(pd_right || pd_all);
        model_hpf(enl, left_sample, xpl, yl, fl);
        model_hpf(enr, right_sample, xpr, yr, fr);
        e.bits = build(codec_ready, slot_sel, enl, enr,
                       hpf_bypass ? left_sample : fl, hpf_bypass ? right_sample : fr);
        e.req = req;
        exp_q.push_back(e);
        sync_in = 1'b1;
        repeat (16) @(negedge clk);
        sync_in = 1'b0;
        for (int i = 0; i < 240; i++) begin
            if (mid_change && i == 80) begin
                left_sample = ~left_sample; right_sample = ~right_sample;
                slot_sel = slot_sel + 2'd1; hpf_bypass = ~hpf_bypass;
                codec_ready = ~codec_ready; pd_all = ~pd_all;
            end
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: detect a frame start, collect 256 bits, compare, check the idle gap.
    initial begin
        logic prev;
        logic [255:0] got;
        exp_t e;
        prev = 1'b0;
        forever begin
            @(posedge clk);
            if (rst_n && sync_in && !prev) begin
                for (int k = 0; k < 256; k++) begin
                    @(posedge clk); @(negedge clk);
                    got[k] = sdata_out;
                end
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected frame: got %h expected none", got);
                end else begin
                    e = exp_q.pop_front();
                    if (got !== e.bits) begin
                        fails++;
                        $display("FAIL %s: got %h expected %h", e.req, got, e.bits);
                    end
                end
                @(posedge clk); @(negedge clk);
                tests++;
                if (sdata_out !== 1'b0) begin
                    fails++;
                    $display("FAIL R11 idle after frame: got %b expected 0", sdata_out);
                end
                prev = sync_in;
            end else begin
                prev = sync_in;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sdata_out !== 1'b0) bad = 1'b1;
        end
        tests++;
        if (bad) begin fails++; $display("FAIL R11 reset idle: got 1 expected 0"); end

        // R3 R4 R1 R2: every select code, raw samples
        set_in(1, 2'b00, 0, 0, 0, 1, 16'h1234, 16'hABCD); run_frame("R1 R2 R3 code00", 0);
        set_in(1, 2'b01, 0, 0, 0, 1, 16'h8001, 16'h7FFE); run_frame("R3 R4 code01", 0);
        set_in(1, 2'b10, 0, 0, 0, 1, 16'hFFFF, 16'h0001); run_frame("R3 R4 code10", 0);
        set_in(1, 2'b11, 0, 0, 0, 1, 16'h5A5A, 16'hA5A5); run_frame("R3 R4 code11", 0);
        // R5 R6: one path down, live sample copied
        set_in(1, 2'b01, 1, 0, 0, 1, 16'h1111, 16'h2222); run_frame("R5 R6 left down", 0);
        set_in(1, 2'b10, 0, 1, 0, 1, 16'h3333, 16'h4444); run_frame("R5 R6 right down", 0);
        // R7 R2: all down, ready low
        set_in(0, 2'b00, 0, 0, 1, 1, 16'h5555, 16'h6666); run_frame("R7 R2 all down", 0);
        // R8: filter on a DC input, state fresh after R7 frame
        set_in(1, 2'b00, 0, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R8 dc step", 0);
        set_in(1, 2'b00, 0, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R8 dc decay", 0);
        set_in(1, 2'b11, 0, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R8 dc decay2", 0);
        // R9: bypass keeps state running
        set_in(1, 2'b11, 0, 0, 0, 1, 16'h4000, 16'hC000); run_frame("R9 bypass", 0);
        set_in(1, 2'b11, 0, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R9 after bypass", 0);
        // R10: left cleared while down, then y = x
        set_in(1, 2'b00, 1, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R10 left down", 0);
        set_in(1, 2'b00, 0, 0, 0, 0, 16'h4000, 16'hC000); run_frame("R10 left back", 0);
        // R8 saturation: negative full scale then positive full scale
        set_in(1, 2'b00, 0, 0, 1, 0, 16'h0, 16'h0);       run_frame("R8 clear", 0);
        set_in(1, 2'b01, 0, 0, 0, 0, 16'h8000, 16'h7FFF); run_frame("R8 full neg", 0);
        set_in(1, 2'b01, 0, 0, 0, 0, 16'h7FFF, 16'h8000); run_frame("R8 saturate", 0);
        // R12: inputs change mid-frame
        set_in(1, 2'b10, 0, 0, 0, 1, 16'h0F0F, 16'hF0F0); run_frame("R12 mid change", 1);
        set_in(1, 2'b10, 0, 0, 0, 1, 16'hCAFE, 16'hBEEF); run_frame("R12 next frame", 0);

        repeat (20) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing frames: got %0d left expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule